// File: doc/BRIEF.md
# Manchester / Clocked-Serial Input Synchronizer

This block is the front end of one serial input channel. It takes a single data line that carries either a Manchester coded stream or plain bits with a separate serial clock. It decides when the receiver has locked onto the stream. It then delivers each recovered bit together with a one-cycle strobe. Both serial lines are first brought into the system clock domain through a two-flop synchronizer. All decisions are then made on the synchronized levels.

After the channel is enabled the block is unsynchronized. In Manchester mode the first data transition of either polarity establishes lock. In clocked mode the first edge of the serial clock, rising or falling, does the same. A clock-absence flag is held set for as long as the channel is unlocked, and a clear pulse has no effect on it during that time. Once lock exists, a clear pulse drops the flag. Software can therefore find lock by clearing the flag and reading it back until it stays clear.

Manchester bits are timed by a programmable divider value D. After a transition that defines a bit, the decoder ignores further transitions until D+1 system clocks have passed. This rejects the boundary transitions that fall between equal bits. Correct reception therefore needs a bit period strictly between D+1 and 2·D system clocks.

Top module: `serial_sync_rx`

## Requirements
- R1: While reset is high or `ch_en` is low, `locked` is 0, `clk_absent` is 1 and `bit_stb` is 0; `bit_stb` is never high while `locked` is 0.
- R2: A change on `ser_data` or `ser_clk` that is sampled at rising edge k reaches `locked`, `bit_stb` and `bit_out` at edge k+2, which is the two-flop synchronizer delay.
- R3: In Manchester mode (`mode_sel`=0), the first synchronized data transition after enable sets `locked`, whether it is 0→1 or 1→0, and that transition also yields a decoded bit.
- R4: In clocked mode (`mode_sel`=1), the first synchronized edge of `ser_clk` sets `locked`, whether it rises or falls, even if that edge is not the sampling edge.
- R5: While the channel is enabled and `locked` is 0, `clk_absent` stays 1 and an `abs_clr` pulse has no effect on it.
- R6: While `locked` is 1, an `abs_clr` sampled at edge k makes `clk_absent` 0 after edge k; the flag then stays 0 while the channel stays enabled.
- R7: In Manchester mode, once locked, a data transition that comes fewer than D+1 cycles after the last accepted transition is ignored, where D is `div_val`. A transition that comes D+1 or more cycles later is accepted. A stream whose bit period lies strictly between D+1 and 2·D cycles is therefore decoded bit for bit, while a period of D cycles or less loses bits.
- R8: Each accepted Manchester transition produces a one-cycle `bit_stb`, with `bit_out` equal to the new line level: a rising transition gives 1 and a falling transition gives 0.
- R9: In clocked mode, `edge_sel`=0 samples `ser_data` on rising `ser_clk` edges and `edge_sel`=1 on falling edges. Each sampling edge gives a one-cycle `bit_stb`, and `bit_out` holds the sampled level.
- R10: Dropping `ch_en` returns the block to the unsynchronized state with `clk_absent` set. A later enable must lock again before any bit is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_en | input | 1 | Channel enable |
| mode_sel | input | 1 | 0 = Manchester, 1 = clocked serial |
| edge_sel | input | 1 | Clocked mode sampling edge: 0 rising, 1 falling |
| ser_data | input | 1 | Serial data line (asynchronous) |
| ser_clk | input | 1 | Serial clock line (asynchronous) |
| div_val | input | DIV_W | Manchester divider value D |
| abs_clr | input | 1 | Clock-absence flag clear pulse |
| bit_out | output | 1 | Most recent recovered bit |
| bit_stb | output | 1 | One-cycle strobe per recovered bit |
| locked | output | 1 | Stream synchronized |
| clk_absent | output | 1 | Clock-absence flag |

## Verification
Lock, strobe and recovered bit are due at the second rising edge after the edge that samples the serial change. The flag reacts to `abs_clr` at the edge that samples it. The bench drives every input just after a falling edge and advances its behavioural reference once per rising edge, keeping the last four samples of each serial line to place events at that two-edge delay. It compares all four outputs at the following falling edge, so each result is read in the cycle it is due. Directed checks on the collected bit queue, lock timing and flag clearing sit on top of that per-cycle comparison.

// File: rtl/ssync_pkg.sv
package ssync_pkg;

    typedef enum logic {
        SER_MANCH = 1'b0,
        SER_SPI   = 1'b1
    } ser_mode_e;

    // synchronized line: current level and "changed this cycle"
    typedef struct packed {
        logic lvl;
        logic chg;
    } line_ev_t;

    // recovered bit: strobe plus held value
    typedef struct packed {
        logic valid;
        logic value;
    } rx_bit_t;

    function automatic logic ev_rise(line_ev_t e);
        return e.chg & e.lvl;
    endfunction

    function automatic logic ev_fall(line_ev_t e);
        return e.chg & ~e.lvl;
    endfunction

endpackage

// File: rtl/ssync_cdc.sv
module ssync_cdc
    import ssync_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     din,
    output line_ev_t ev
);
    // STAGES synchronizer flops plus one history flop for edge detection
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], din};
    end

    assign ev.lvl = sh[STAGES-1];
    assign ev.chg = sh[STAGES-1] ^ sh[STAGES];

endmodule

// File: rtl/ssync_manch.sv
module ssync_manch
    import ssync_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             locked,
    input  line_ev_t         data_ev,
    input  logic [DIV_W-1:0] div_val,
    output rx_bit_t          rx
);
    localparam int CNT_W = DIV_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] gap_cnt;
    logic             gap_ok;
    logic             accept;

    // distance since last accepted transition is gap_cnt+1; need >= D+1
    assign gap_ok = gap_cnt >= {1'b0, div_val};
    assign accept = en & data_ev.chg & (~locked | gap_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_cnt  <= '0;
            rx.valid <= 1'b0;
            rx.value <= 1'b0;
        end else if (!en) begin
            gap_cnt  <= '0;
            rx.valid <= 1'b0;
        end else begin
            rx.valid <= 1'b0;
            if (accept) begin
                rx.valid <= 1'b1;
                rx.value <= data_ev.lvl;
                gap_cnt  <= '0;
            end else if (gap_cnt != CNT_MAX) begin
                gap_cnt <= gap_cnt + 1'b1;
            end
        end
    end

    // R7: a transition inside the guard window gives no bit
    p_guard_window_r7: assert property (@(posedge clk) disable iff (rst)
        (en && locked && data_ev.chg && (gap_cnt < {1'b0, div_val})) |=> !rx.valid);

    // R8: the strobe lasts a single cycle
    p_stb_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        (rx.valid && div_val != '0) |=> !rx.valid);

endmodule

// File: rtl/ssync_spi.sv
module ssync_spi
    import ssync_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     edge_sel,
    input  line_ev_t clk_ev,
    input  logic     data_lvl,
    output rx_bit_t  rx
);
    logic take;

    assign take = en & (edge_sel ? ev_fall(clk_ev) : ev_rise(clk_ev));

    always_ff @(posedge clk) begin
        if (rst) begin
            rx.valid <= 1'b0;
            rx.value <= 1'b0;
        end else begin
            rx.valid <= take;
            if (take) rx.value <= data_lvl;
        end
    end

    // R9: a selected-polarity clock edge always yields a strobe
    p_sample_edge_r9: assert property (@(posedge clk) disable iff (rst)
        (en && clk_ev.chg && (clk_ev.lvl != edge_sel)) |=> rx.valid);

endmodule

// File: rtl/ssync_lock.sv
module ssync_lock
    import ssync_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ch_en,
    input  ser_mode_e mode,
    input  logic      data_chg,
    input  logic      clk_chg,
    input  logic      abs_clr,
    output logic      locked,
    output logic      absent
);
    logic lock_ev;

    assign lock_ev = (mode == SER_SPI) ? clk_chg : data_chg;

    always_ff @(posedge clk) begin
        if (rst || !ch_en) begin
            locked <= 1'b0;
            absent <= 1'b1;
        end else begin
            if (lock_ev) locked <= 1'b1;
            if (!locked)      absent <= 1'b1;
            else if (abs_clr) absent <= 1'b0;
        end
    end

    // R5: clear request while unlocked leaves the flag set
    p_clr_ignored_r5: assert property (@(posedge clk) disable iff (rst)
        (abs_clr && !locked) |=> absent);

    // R6: clear request while locked and enabled drops the flag
    p_clr_taken_r6: assert property (@(posedge clk) disable iff (rst)
        (ch_en && locked && abs_clr) |=> !absent);

    // R10: disable returns to unsynchronized with flag set
    p_disable_r10: assert property (@(posedge clk) disable iff (rst)
        !ch_en |=> (!locked && absent));

endmodule

// File: rtl/serial_sync_rx.sv
module serial_sync_rx
    import ssync_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ch_en,
    input  logic             mode_sel,
    input  logic             edge_sel,
    input  logic             ser_data,
    input  logic             ser_clk,
    input  logic [DIV_W-1:0] div_val,
    input  logic             abs_clr,
    output logic             bit_out,
    output logic             bit_stb,
    output logic             locked,
    output logic             clk_absent
);
    localparam int N_LINES = 2;
    localparam int L_DATA  = 0;
    localparam int L_CLK   = 1;

    ser_mode_e            mode;
    logic [N_LINES-1:0]   raw;
    line_ev_t             line_ev [N_LINES];
    rx_bit_t              man_rx;
    rx_bit_t              spi_rx;

    assign mode        = ser_mode_e'(mode_sel);
    assign raw[L_DATA] = ser_data;
    assign raw[L_CLK]  = ser_clk;

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        ssync_cdc #(.STAGES(SYNC_STAGES)) u_cdc (
            .clk (clk),
            .rst (rst),
            .din (raw[g]),
            .ev  (line_ev[g])
        );
    end

    ssync_lock u_lock (
        .clk      (clk),
        .rst      (rst),
        .ch_en    (ch_en),
        .mode     (mode),
        .data_chg (line_ev[L_DATA].chg),
        .clk_chg  (line_ev[L_CLK].chg),
        .abs_clr  (abs_clr),
        .locked   (locked),
        .absent   (clk_absent)
    );

    ssync_manch #(.DIV_W(DIV_W)) u_manch (
        .clk     (clk),
        .rst     (rst),
        .en      (ch_en && mode == SER_MANCH),
        .locked  (locked),
        .data_ev (line_ev[L_DATA]),
        .div_val (div_val),
        .rx      (man_rx)
    );

    ssync_spi u_spi (
        .clk      (clk),
        .rst      (rst),
        .en       (ch_en && mode == SER_SPI),
        .edge_sel (edge_sel),
        .clk_ev   (line_ev[L_CLK]),
        .data_lvl (line_ev[L_DATA].lvl),
        .rx       (spi_rx)
    );

    assign bit_stb = man_rx.valid | spi_rx.valid;
    assign bit_out = (mode == SER_SPI) ? spi_rx.value : man_rx.value;

    // R1: no bit is ever delivered without lock
    p_stb_needs_lock_r1: assert property (@(posedge clk) disable iff (rst)
        bit_stb |-> locked);

    // R1: reset state of the status outputs
    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> (!locked && clk_absent && !bit_stb));

endmodule

// File: tb/test_serial_sync_rx.sv
module test_serial_sync_rx;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 8;
    localparam int CNT_MAX    = (1 << (DIV_W + 1)) - 1;
    localparam int WD_CYCLES  = 100000;

    logic clk = 1'b0;
    logic rst, ch_en, mode_sel, edge_sel, ser_data, ser_clk, abs_clr;
    logic [DIV_W-1:0] div_val;
    logic bit_out, bit_stb, locked, clk_absent;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_sync_rx #(.DIV_W(DIV_W)) i_serial_sync_rx (
        .clk(clk), .rst(rst), .ch_en(ch_en), .mode_sel(mode_sel),
        .edge_sel(edge_sel), .ser_data(ser_data), .ser_clk(ser_clk),
        .div_val(div_val), .abs_clr(abs_clr), .bit_out(bit_out),
        .bit_stb(bit_stb), .locked(locked), .clk_absent(clk_absent)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string cur_req = "R1";

    // reference state
    int  dq[$];
    int  cq[$];
    int  m_locked, m_flag, m_stb, m_bitm, m_bits, m_cnt;
    logic rxq[$];

    task automatic check(string req, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int dev, cev, crise, dlvl, old_locked;
        if (rst) begin
            dq = {0, 0, 0, 0};
            cq = {0, 0, 0, 0};
            m_locked = 0; m_flag = 1; m_stb = 0;
            m_bitm = 0; m_bits = 0; m_cnt = 0;
            return;
        end
        dq.push_front(int'(ser_data)); void'(dq.pop_back());
        cq.push_front(int'(ser_clk));  void'(cq.pop_back());
        dlvl  = dq[2];
        dev   = (dq[2] != dq[3]);
        cev   = (cq[2] != cq[3]);
        crise = cq[2];
        old_locked = m_locked;
        m_stb = 0;
        if (!ch_en) begin
            m_locked = 0; m_flag = 1; m_cnt = 0;
            return;
        end
        if (mode_sel) begin
            m_cnt = 0;
            if (cev) m_locked = 1;
            if (cev && (crise == (edge_sel ? 0 : 1))) begin
                m_bits = dlvl; m_stb = 1;
            end
        end else begin
            if (dev && (!old_locked || m_cnt >= int'(div_val))) begin
                m_bitm = dlvl; m_stb = 1; m_cnt = 0;
            end else if (m_cnt < CNT_MAX) begin
                m_cnt++;
            end
            if (dev) m_locked = 1;
        end
        if (!old_locked)  m_flag = 1;
        else if (abs_clr) m_flag = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(cur_req, "locked",     int'(locked),     m_locked);
        check(cur_req, "clk_absent", int'(clk_absent), m_flag);
        check(cur_req, "bit_stb",    int'(bit_stb),    m_stb);
        check(cur_req, "bit_out",    int'(bit_out),    mode_sel ? m_bits : m_bitm);
        if (bit_stb) rxq.push_back(bit_out);
    endtask

    task automatic send_manch(logic b, int half);
        ser_data = ~b;
        repeat (half) tick();
        ser_data = b;
        repeat (half) tick();
    endtask

    task automatic send_spi(logic b, logic fall_sample);
        ser_data = b;
        repeat (3) tick();
        ser_clk = 1'b1;
        repeat (3) tick();
        ser_clk = 1'b0;
        repeat (fall_sample ? 3 : 2) tick();
    endtask

    task automatic check_rx(string req, logic [7:0] pat, int nbits);
        check(req, "bit count", rxq.size(), nbits);
        for (int i = 0; i < nbits && i < rxq.size(); i++)
            check(req, "bit value", int'(rxq[i]), int'(pat[nbits-1-i]));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1; ch_en = 0; mode_sel = 0; edge_sel = 0;
        ser_data = 0; ser_clk = 0; abs_clr = 0; div_val = 8'd4;
        @(negedge clk);

        // R1: reset and disabled state
        cur_req = "R1";
        repeat (3) tick();
        rst = 0;
        repeat (4) tick();
        check("R1", "clk_absent after reset", int'(clk_absent), 1);

        // R5: clear while enabled but unlocked is ignored
        cur_req = "R5";
        ch_en = 1;
        repeat (2) tick();
        abs_clr = 1; tick(); abs_clr = 0; tick();
        check("R5", "flag after early clear", int'(clk_absent), 1);
        check("R5", "still unlocked", int'(locked), 0);

        // R3/R8: Manchester, D=4, period 6, lock on rising mid transition
        cur_req = "R3";
        rxq.delete();
        for (int i = 7; i >= 0; i--) send_manch(8'b1011_0010 >> i, 3);
        repeat (8) tick();
        check("R3", "locked after stream", int'(locked), 1);
        check_rx("R8", 8'b1011_0010, 8);

        // R6: clear after lock
        cur_req = "R6";
        abs_clr = 1; tick(); abs_clr = 0;
        check("R6", "flag after clear", int'(clk_absent), 0);
        repeat (5) tick();
        check("R6", "flag stays clear", int'(clk_absent), 0);

        // R10: disable returns to unsynchronized
        cur_req = "R10";
        ch_en = 0; ser_data = 1;
        repeat (5) tick();
        check("R10", "locked after disable", int'(locked), 0);
        check("R10", "flag after disable", int'(clk_absent), 1);

        // R3/R7: D=6, period 10, idle high, lock on falling transition
        cur_req = "R7";
        div_val = 8'd6; ch_en = 1; rxq.delete();
        repeat (3) tick();
        check("R10", "no lock without new transition", int'(locked), 0);
        for (int i = 4; i >= 0; i--) send_manch(5'b01101 >> i, 5);
        repeat (10) tick();
        check_rx("R7", 8'b0000_1101, 5);
        check("R3", "first decoded bit from falling edge", int'(rxq[0]), 0);

        // R7: period equal to D loses bits
        ch_en = 0; ser_data = 0; div_val = 8'd4;
        repeat (5) tick();
        ch_en = 1; rxq.delete();
        for (int i = 3; i >= 0; i--) send_manch(4'b1010 >> i, 2);
        repeat (8) tick();
        check("R7", "bits kept at too-short period", rxq.size(), 2);

        // R4/R2: clocked mode, first edge falling locks without sampling
        cur_req = "R4";
        ch_en = 0; mode_sel = 1; edge_sel = 0; ser_clk = 1; ser_data = 0;
        repeat (5) tick();
        ch_en = 1; rxq.delete();
        tick();
        abs_clr = 1; tick(); abs_clr = 0;
        check("R5", "flag held while clocked mode unlocked", int'(clk_absent), 1);
        ser_clk = 0;
        tick(); tick();
        check("R2", "lock not yet visible one edge after sampling", int'(locked), 0);
        tick();
        check("R4", "locked on falling clock edge", int'(locked), 1);
        check("R9", "no sample on non-selected edge", rxq.size(), 0);

        // R9: rising-edge sampling
        cur_req = "R9";
        for (int i = 5; i >= 0; i--) send_spi(6'b110100 >> i, 1'b0);
        check_rx("R9", 8'b0011_0100, 6);

        // R9: falling-edge sampling, first rise locks
        ch_en = 0; edge_sel = 1;
        repeat (5) tick();
        ch_en = 1; rxq.delete();
        for (int i = 5; i >= 0; i--) send_spi(6'b011001 >> i, 1'b1);
        check("R4", "locked in falling mode", int'(locked), 1);
        check_rx("R9", 8'b0001_1001, 6);

        repeat (4) tick();
        finish_run();
    end
endmodule